// File: doc/BRIEF.md
# SD Card Data Block Write Framer

This block sends one data block from a byte-wide staging buffer to an SD card during a single-block write. It produces one bit per clock on the card data lines, either on one line or striped across four. Every line in use carries a start bit, its share of the block, a 16-bit CRC computed over its own bits, and an end bit. The block fetches bytes through a read port whose data is valid in the same cycle as the address. The buffer is read in ascending address order, and the most significant bits of each byte go out first.

When the block has been sent, the framer stops driving the lines. It then watches data line 0 for the card's CRC status token and decodes it. After the token it waits while the card holds the line low to signal that it is busy. A one-cycle completion pulse marks the end of the transfer. It comes with a flag saying whether the card rejected the block and a flag saying whether a wait ran out of time. The clock is the card clock, so one line bit lasts one cycle.

Top module: `sd_blk_wr_framer`

## Requirements
- R1: After `start` is accepted in idle, every active line is driven with a start bit 0 for one cycle, then its data bits, then 16 CRC bits, then an end bit 1 for one cycle. The drive window is therefore 1 + data cycles + 17 cycles long.
- R2: With `wide_mode`=0, only line 0 is driven (`dat_oe`=4'b0001), and lines 3..1 read 1. Over `blk_len`*8 cycles it sends byte 0 to byte `blk_len`-1, bit 7 first within each byte. `buf_addr` is the byte in use.
- R3: With `wide_mode`=1, all four lines are driven (`dat_oe`=4'b1111) for `blk_len`*2 data cycles. The first cycle of each byte puts byte bits 7,6,5,4 on lines 3,2,1,0. The second cycle puts bits 3,2,1,0 on lines 3,2,1,0.
- R4: Each active line's CRC16 uses generator x^16+x^12+x^5+1 (0x1021) and a zero start value. It covers only that line's data bits and is sent most significant bit first, between the data and the end bit.
- R5: Once the end bit has been sent, `dat_oe` is 0, and `dat_out` reads 4'hF on every undriven line at all times.
- R6: After release, the first 0 sampled on `dat_in[0]` is the token start bit. The next three samples form the token, first bit most significant. The cycle after them is the token end bit and is ignored. Token 3'b010 leaves `crc_err` at 0, and any other value sets it to 1.
- R7: After the token end bit, the framer waits while `dat_in[0]` is 0. In the cycle after it samples `dat_in[0]`=1, `done` is high for exactly one cycle. `crc_err` and `tmo_err` are valid with `done` and hold until the next accepted `start`.
- R8: If `dat_in[0]` stays 1 while the framer waits for the token start, or stays 0 during busy, for `busy_limit` consecutive samples (0 counts as 1), `done` pulses with `tmo_err`=1. A timeout before the token leaves `crc_err`=0.
- R9: After reset, `dat_oe`=0, `dat_out`=4'hF, and `done`, `crc_err` and `tmo_err` are 0. `start` is ignored while a block or its response is in progress.
- R10: `wide_mode` and `blk_len` (1 to MAX_LEN bytes) are captured when `start` is accepted. Changing them during the transfer has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card clock, one line bit per cycle |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse to begin a block |
| wide_mode | input | 1 | 1 = four lines, 0 = line 0 only |
| blk_len | input | LEN_W | Block length in bytes |
| busy_limit | input | TMO_W | Wait timeout in cycles |
| buf_addr | output | LEN_W | Buffer byte address |
| buf_data | input | 8 | Buffer byte at `buf_addr` |
| dat_in | input | 4 | Sampled card data lines |
| dat_out | output | 4 | Data line drive values |
| dat_oe | output | 4 | Data line drive enables |
| done | output | 1 | One-cycle completion pulse |
| crc_err | output | 1 | Card rejected the block |
| tmo_err | output | 1 | A response wait timed out |

## Verification
The block is run with full 512-byte blocks in both modes, which exercises the bit counter and the nibble order end to end. It is also run with one- and three-byte blocks, which expose off-by-one errors at the data-to-CRC boundary. Random buffer contents and random lengths in both modes separate lane striping errors from CRC feedback errors, because each line's CRC is predicted on its own.

The response stimulus varies several things: the idle gap before the token, the token value (accepted and rejected), and busy lengths including zero. Waits are placed on either side of the limit, and a zero limit is also tried, so that timeouts in the token wait and in the busy wait are told apart from normal completion. A run changes the mode and length inputs and pulses `start` mid-transfer, which shows that the captured settings and the idle-only start rule hold.

// File: rtl/sdw_pkg.sv
package sdw_pkg;

    localparam int CRC_W = 16;
    localparam logic [CRC_W-1:0] CRC_GEN = 16'h1021;
    localparam logic [2:0] TOKEN_OK = 3'b010;

    // transmit sequencer states
    typedef enum logic [2:0] {
        TX_IDLE,
        TX_SBIT,
        TX_DATA,
        TX_CRC,
        TX_EBIT,
        TX_RESP
    } tx_state_e;

    // response monitor states
    typedef enum logic [2:0] {
        RM_IDLE,
        RM_WAIT,
        RM_TOK,
        RM_TEND,
        RM_BUSY
    } rm_state_e;

    typedef struct packed {
        logic fin;
        logic tok_bad;
        logic tmo;
    } rsp_flags_t;

    function automatic logic [CRC_W-1:0] crc16_next(input logic [CRC_W-1:0] c,
                                                      input logic b);
        logic fb;
        fb = c[CRC_W-1] ^ b;
        return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_GEN : '0);
    endfunction

endpackage

// File: rtl/sdw_crc_lane.sv
module sdw_crc_lane
    import sdw_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic upd,
    input  logic bit_in,
    input  logic shift,
    output logic msb
);
    logic [CRC_W-1:0] crc_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            crc_q <= '0;
        end else if (upd) begin
            crc_q <= crc16_next(crc_q, bit_in);
        end else if (shift) begin
            crc_q <= {crc_q[CRC_W-2:0], 1'b0};
        end
    end

    assign msb = crc_q[CRC_W-1];
endmodule

// File: rtl/sdw_tx_mux.sv
module sdw_tx_mux #(
    parameter int LEN_W = 10,
    parameter int BIT_W = 13
) (
    input  logic             wide,
    input  logic [BIT_W-1:0] idx,
    input  logic [7:0]       byte_in,
    output logic [LEN_W-1:0] addr,
    output logic [3:0]       bits
);
    logic [3:0] nib;

    always_comb begin
        if (wide) begin
            addr = LEN_W'(idx >> 1);
        end else begin
            addr = LEN_W'(idx >> 3);
        end
        nib = idx[0] ? byte_in[3:0] : byte_in[7:4];
    end

    // lane 0 carries either the serial bit or nibble bit 0; others only in wide mode
    always_comb begin
        bits[0] = wide ? nib[0] : byte_in[3'd7 - idx[2:0]];
    end

    for (genvar g = 1; g < 4; g++) begin : g_lane
        always_comb bits[g] = wide & nib[g];
    end
endmodule

// File: rtl/sdw_rsp_mon.sv
module sdw_rsp_mon
    import sdw_pkg::*;
#(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             arm,
    input  logic             dat0,
    input  logic [TMO_W-1:0] limit,
    output rsp_flags_t       flags
);
    rm_state_e        st_q;
    logic [TMO_W-1:0] wcnt_q;
    logic [1:0]       tcnt_q;
    logic [2:0]       tok_q;
    logic             lim_hit;

    assign lim_hit = ({1'b0, wcnt_q} + 1'b1) >= {1'b0, limit};

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= RM_IDLE;
            wcnt_q <= '0;
            tcnt_q <= '0;
            tok_q  <= '0;
            flags  <= '0;
        end else begin
            flags.fin <= 1'b0;
            if (clr) begin
                flags.tok_bad <= 1'b0;
                flags.tmo     <= 1'b0;
            end
            unique case (st_q)
                RM_IDLE: begin
                    if (arm) begin
                        st_q   <= RM_WAIT;
                        wcnt_q <= '0;
                    end
                end
                RM_WAIT: begin
                    if (!dat0) begin
                        st_q   <= RM_TOK;
                        tcnt_q <= '0;
                    end else if (lim_hit) begin
                        st_q      <= RM_IDLE;
                        flags.fin <= 1'b1;
                        flags.tmo <= 1'b1;
                    end else begin
                        wcnt_q <= wcnt_q + 1'b1;
                    end
                end
                RM_TOK: begin
                    tok_q  <= {tok_q[1:0], dat0};
                    tcnt_q <= tcnt_q + 1'b1;
                    if (tcnt_q == 2'd2) st_q <= RM_TEND;
                end
                RM_TEND: begin
                    flags.tok_bad <= (tok_q != TOKEN_OK);
                    st_q          <= RM_BUSY;
                    wcnt_q        <= '0;
                end
                RM_BUSY: begin
                    if (dat0) begin
                        st_q      <= RM_IDLE;
                        flags.fin <= 1'b1;
                    end else if (lim_hit) begin
                        st_q      <= RM_IDLE;
                        flags.fin <= 1'b1;
                        flags.tmo <= 1'b1;
                    end else begin
                        wcnt_q <= wcnt_q + 1'b1;
                    end
                end
                default: st_q <= RM_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sd_blk_wr_framer.sv
module sd_blk_wr_framer
    import sdw_pkg::*;
#(
    parameter int MAX_LEN = 512,
    parameter int TMO_W   = 16,
    localparam int LEN_W  = $clog2(MAX_LEN + 1),
    localparam int BIT_W  = $clog2(MAX_LEN * 8 + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             wide_mode,
    input  logic [LEN_W-1:0] blk_len,
    input  logic [TMO_W-1:0] busy_limit,
    output logic [LEN_W-1:0] buf_addr,
    input  logic [7:0]       buf_data,
    input  logic [3:0]       dat_in,
    output logic [3:0]       dat_out,
    output logic [3:0]       dat_oe,
    output logic             done,
    output logic             crc_err,
    output logic             tmo_err
);
    tx_state_e        st_q;
    logic             wide_q;
    logic [LEN_W-1:0] len_q;
    logic [BIT_W-1:0] cnt_q;
    logic [BIT_W-1:0] nbits;
    logic [3:0]       act;
    logic [3:0]       lane_bits;
    logic [3:0]       crc_msb;
    logic             accept;
    rsp_flags_t       rsp;

    assign accept = (st_q == TX_IDLE) && start;
    assign act    = wide_q ? 4'b1111 : 4'b0001;
    assign nbits  = wide_q ? (BIT_W'(len_q) << 1) : (BIT_W'(len_q) << 3);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= TX_IDLE;
            wide_q <= 1'b0;
            len_q  <= '0;
            cnt_q  <= '0;
        end else begin
            unique case (st_q)
                TX_IDLE: begin
                    if (start) begin
                        wide_q <= wide_mode;
                        len_q  <= blk_len;
                        cnt_q  <= '0;
                        st_q   <= TX_SBIT;
                    end
                end
                TX_SBIT: st_q <= TX_DATA;
                TX_DATA: begin
                    if (cnt_q == nbits - 1'b1) begin
                        cnt_q <= '0;
                        st_q  <= TX_CRC;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                TX_CRC: begin
                    if (cnt_q == BIT_W'(CRC_W - 1)) begin
                        cnt_q <= '0;
                        st_q  <= TX_EBIT;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                TX_EBIT: st_q <= TX_RESP;
                TX_RESP: if (rsp.fin) st_q <= TX_IDLE;
                default: st_q <= TX_IDLE;
            endcase
        end
    end

    sdw_tx_mux #(
        .LEN_W(LEN_W),
        .BIT_W(BIT_W)
    ) i_mux (
        .wide   (wide_q),
        .idx    (cnt_q),
        .byte_in(buf_data),
        .addr   (buf_addr),
        .bits   (lane_bits)
    );

    for (genvar g = 0; g < 4; g++) begin : g_crc
        sdw_crc_lane i_crc (
            .clk   (clk),
            .rst   (rst),
            .clr   (accept),
            .upd   ((st_q == TX_DATA) && act[g]),
            .bit_in(lane_bits[g]),
            .shift (st_q == TX_CRC),
            .msb   (crc_msb[g])
        );
    end

    always_comb begin
        dat_oe  = 4'b0000;
        dat_out = 4'b1111;
        unique case (st_q)
            TX_SBIT: begin dat_oe = act; dat_out = ~act; end
            TX_DATA: begin dat_oe = act; dat_out = lane_bits | ~act; end
            TX_CRC:  begin dat_oe = act; dat_out = crc_msb | ~act; end
            TX_EBIT: begin dat_oe = act; dat_out = 4'b1111; end
            default: ;
        endcase
    end

    sdw_rsp_mon #(
        .TMO_W(TMO_W)
    ) i_rsp (
        .clk  (clk),
        .rst  (rst),
        .clr  (accept),
        .arm  (st_q == TX_EBIT),
        .dat0 (dat_in[0]),
        .limit(busy_limit),
        .flags(rsp)
    );

    assign done    = rsp.fin;
    assign crc_err = rsp.tok_bad;
    assign tmo_err = rsp.tmo;
endmodule

// File: rtl/sdw_framer_chk.sv
module sdw_framer_chk (
    input logic       clk,
    input logic       rst,
    input logic [3:0] dat_out,
    input logic [3:0] dat_oe,
    input logic       done
);
    // R2/R3: only the one-line or four-line enable pattern ever appears
    a_r3_oe_pattern: assert property (@(posedge clk) disable iff (rst)
        (dat_oe == 4'b0000) || (dat_oe == 4'b0001) || (dat_oe == 4'b1111));

    // R5: undriven lines read 1
    a_r5_released_high: assert property (@(posedge clk) disable iff (rst)
        ((~dat_oe & ~dat_out) == 4'b0000));

    // R1: the first driven cycle carries the start bit
    a_r1_start_zero: assert property (@(posedge clk) disable iff (rst)
        $rose(dat_oe[0]) |-> (dat_out[0] == 1'b0));

    // R1: the last driven cycle carries the end bit
    a_r1_end_high: assert property (@(posedge clk) disable iff (rst)
        $fell(dat_oe[0]) |-> $past(dat_out[0]));

    // R10: the enable pattern does not change inside one block
    a_r10_oe_steady: assert property (@(posedge clk) disable iff (rst)
        ((dat_oe != 4'b0000) && $past(dat_oe != 4'b0000)) |-> $stable(dat_oe));

    // R7: completion is a single-cycle pulse
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7: nothing is driven while completion is signalled
    a_r7_done_released: assert property (@(posedge clk) disable iff (rst)
        done |-> (dat_oe == 4'b0000));
endmodule

bind sd_blk_wr_framer sdw_framer_chk i_chk (
    .clk    (clk),
    .rst    (rst),
    .dat_out(dat_out),
    .dat_oe (dat_oe),
    .done   (done)
);

// File: tb/test_sd_blk_wr_framer.sv
module test_sd_blk_wr_framer;
    localparam int MAX_LEN = 512;
    localparam int TMO_W   = 16;
    localparam int LEN_W   = $clog2(MAX_LEN + 1);
    localparam int CAPN    = MAX_LEN * 8 + 40;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic             wide_mode = 1'b0;
    logic [LEN_W-1:0] blk_len = '0;
    logic [TMO_W-1:0] busy_limit = '0;
    logic [LEN_W-1:0] buf_addr;
    logic [7:0]       buf_data;
    logic [3:0]       dat_in = 4'hF;
    logic [3:0]       dat_out;
    logic [3:0]       dat_oe;
    logic             done;
    logic             crc_err;
    logic             tmo_err;

    logic [7:0] mem [0:MAX_LEN-1];
    logic       cap [0:3][0:CAPN-1];
    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    always #5 clk = ~clk;

    assign buf_data = mem[buf_addr];

    sd_blk_wr_framer #(
        .MAX_LEN(MAX_LEN),
        .TMO_W  (TMO_W)
    ) i_sd_blk_wr_framer (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .wide_mode (wide_mode),
        .blk_len   (blk_len),
        .busy_limit(busy_limit),
        .buf_addr  (buf_addr),
        .buf_data  (buf_data),
        .dat_in    (dat_in),
        .dat_out   (dat_out),
        .dat_oe    (dat_oe),
        .done      (done),
        .crc_err   (crc_err),
        .tmo_err   (tmo_err)
    );

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    function automatic logic exp_bit(input bit wide, input int lane, input int i);
        if (wide) return mem[i / 2][(i % 2 == 0) ? 4 + lane : lane];
        return mem[i / 8][7 - (i % 8)];
    endfunction

    function automatic logic [15:0] exp_crc(input bit wide, input int lane, input int nb);
        logic [15:0] c = 16'h0000;
        for (int i = 0; i < nb; i++) begin
            logic fb = c[15] ^ exp_bit(wide, lane, i);
            c = {c[14:0], 1'b0};
            if (fb) c = c ^ 16'h1021;
        end
        return c;
    endfunction

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 190000) begin
                bad++;
                total++;
                $display("FAIL watchdog: run did not finish, cycle=%0d", cyc);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    task automatic run_block(input bit wide, input int len, input int pad,
                             input logic [2:0] tok, input int busy, input int lim,
                             input bit perturb);
        int nb, n, k, got, lim_eff, exp_k;
        int data_bad, crc_bad, frame_bad, idle_bad, oe_bad, resp_oe_bad;
        bit got_crc, got_tmo, exp_tmo, exp_crc_e, late_done;
        string drq;
        nb = wide ? len * 2 : len * 8;
        lim_eff = (lim < 1) ? 1 : lim;
        for (int i = 0; i < len; i++) mem[i] = 8'($urandom);
        // N0: request
        wide_mode  = wide;
        blk_len    = LEN_W'(len);
        busy_limit = TMO_W'(lim);
        start      = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (perturb) begin
            wide_mode = ~wide;
            blk_len   = LEN_W'(len + 7);
        end
        n = 0; idle_bad = 0; oe_bad = 0;
        while (dat_oe != 4'b0000 && n < CAPN) begin
            for (int l = 0; l < 4; l++) cap[l][n] = dat_out[l];
            if (dat_oe != (wide ? 4'b1111 : 4'b0001)) oe_bad++;
            if (!wide && dat_out[3:1] != 3'b111) idle_bad++;
            if (perturb && n == 3) start = 1'b1;
            if (perturb && n == 4) start = 1'b0;
            n++;
            @(negedge clk);
        end
        chk(n == nb + 18, "R1", "drive window length", n, nb + 18);
        chk(oe_bad == 0, wide ? "R3" : "R2", "enable pattern mismatches", oe_bad, 0);
        if (!wide) chk(idle_bad == 0, "R2", "lines 3..1 not high", idle_bad, 0);
        drq = perturb ? "R10" : (wide ? "R3" : "R2");
        if (n == nb + 18) begin
            frame_bad = 0; data_bad = 0; crc_bad = 0;
            for (int l = 0; l < (wide ? 4 : 1); l++) begin
                logic [15:0] c = exp_crc(wide, l, nb);
                if (cap[l][0] !== 1'b0) frame_bad++;
                if (cap[l][nb + 17] !== 1'b1) frame_bad++;
                for (int i = 0; i < nb; i++)
                    if (cap[l][1 + i] !== exp_bit(wide, l, i)) data_bad++;
                for (int j = 0; j < 16; j++)
                    if (cap[l][1 + nb + j] !== c[15 - j]) crc_bad++;
            end
            chk(frame_bad == 0, "R1", "start/end bit errors", frame_bad, 0);
            chk(data_bad == 0, drq, "data bit errors", data_bad, 0);
            chk(crc_bad == 0, "R4", "crc bit errors", crc_bad, 0);
        end
        chk(dat_out == 4'hF && dat_oe == 4'h0, "R5", "released lines", {dat_oe, dat_out}, 8'h0F);
        // expected response outcome
        if (pad >= lim_eff) begin
            exp_tmo = 1; exp_crc_e = 0; exp_k = lim_eff;
        end else if (busy >= lim_eff) begin
            exp_tmo = 1; exp_crc_e = (tok != 3'b010); exp_k = pad + 5 + lim_eff;
        end else begin
            exp_tmo = 0; exp_crc_e = (tok != 3'b010); exp_k = pad + 6 + busy;
        end
        got = -1; got_crc = 0; got_tmo = 0; resp_oe_bad = 0; late_done = 0;
        fork
            begin
                for (int j = 0; j < pad; j++) begin dat_in[0] = 1'b1; @(negedge clk); end
                dat_in[0] = 1'b0; @(negedge clk);
                for (int t = 2; t >= 0; t--) begin dat_in[0] = tok[t]; @(negedge clk); end
                dat_in[0] = 1'b1; @(negedge clk);
                for (int b = 0; b < busy; b++) begin
                    if (perturb && b == 0) start = 1'b1;
                    dat_in[0] = 1'b0;
                    @(negedge clk);
                    start = 1'b0;
                end
                dat_in[0] = 1'b1;
            end
            begin
                for (k = 1; k < 4000; k++) begin
                    @(negedge clk);
                    if (dat_oe != 4'b0000) resp_oe_bad++;
                    if (done) begin
                        got = k; got_crc = crc_err; got_tmo = tmo_err;
                        break;
                    end
                end
                @(negedge clk);
                if (done) late_done = 1;
            end
        join
        repeat (3) begin
            if (dat_oe != 4'b0000) resp_oe_bad++;
            @(negedge clk);
        end
        chk(got == exp_k, "R7", "done cycle after release", got, exp_k);
        chk(!late_done, "R7", "done longer than one cycle", late_done, 0);
        chk(got_crc == exp_crc_e, "R6", "crc_err at done", got_crc, exp_crc_e);
        chk(got_tmo == exp_tmo, "R8", "tmo_err at done", got_tmo, exp_tmo);
        chk(resp_oe_bad == 0, "R9", "drive during response/after done", resp_oe_bad, 0);
        chk(crc_err == exp_crc_e && tmo_err == exp_tmo, "R7", "flags held after done",
            {crc_err, tmo_err}, {exp_crc_e, exp_tmo});
    endtask

    initial begin
        int seed_init;
        seed_init = $urandom(32'h5D17A3);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(dat_oe == 4'h0 && dat_out == 4'hF, "R9", "reset drive state", {dat_oe, dat_out}, 8'h0F);
        chk(!done && !crc_err && !tmo_err, "R9", "reset flags", {done, crc_err, tmo_err}, 0);

        run_block(1'b0, 512, 2, 3'b010, 5, 100, 1'b0);  // R2 full block
        run_block(1'b1, 512, 1, 3'b010, 3, 100, 1'b0);  // R3 full block
        run_block(1'b1, 1, 0, 3'b101, 2, 50, 1'b0);     // R6 rejected token
        run_block(1'b0, 3, 4, 3'b010, 0, 50, 1'b0);     // R7 no busy
        run_block(1'b0, 2, 10, 3'b010, 2, 4, 1'b0);     // R8 token wait timeout
        run_block(1'b1, 4, 1, 3'b010, 20, 8, 1'b0);     // R8 busy timeout
        run_block(1'b1, 2, 0, 3'b111, 1, 0, 1'b0);      // R8 zero limit
        run_block(1'b1, 6, 2, 3'b010, 4, 40, 1'b1);     // R10 and R9 ignored start
        run_block(1'b0, 5, 1, 3'b011, 6, 40, 1'b1);     // R10 one-line
        for (int r = 0; r < 8; r++) begin
            run_block(1'($urandom), 1 + int'($urandom_range(0, 63)),
                      int'($urandom_range(0, 5)), 3'($urandom),
                      int'($urandom_range(0, 10)), 30, 1'b0);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule